// File: doc/BRIEF.md
# Pipelined Table-Assisted Floating-Point Divider

This block divides two packed floating-point numbers of configurable exponent and fraction width and returns a new quotient every clock. The sign of the quotient is the exclusive-or of the operand signs. The exponent is the difference of the operand exponents with the bias added back. The mantissa quotient is not produced by a digit recurrence. Instead the divisor mantissa is split into a high part Yh and a low part Yl. A table indexed by the high part supplies 1/Yh². Two multipliers then form X·(Yh−Yl)·(1/Yh²), which is a first-order series approximation of X/Y.

An operation is presented with a strobe on `ready_i` and comes out four clocks later with a strobe on `done_o`. Zeros, subnormals, infinities and NaNs are not handled as values. Any operand whose exponent field is all zeros or all ones raises the exception output, and so does a result exponent that falls outside the normal range. An exception flag that arrives with the operands travels alongside the data and comes out on `exc_o`.

Top module: `fpdiv_taylor`

## Requirements
- R1: The sign bit of a non-exceptional quotient is the exclusive-or of the two operand sign bits.
- R2: When the dividend mantissa (hidden one included) is smaller than the divisor mantissa, the result exponent field equals ea − eb + bias − 1. Here bias = 2^(EXP_W−1) − 1, and the exponent field lies directly below the sign bit, which is the most significant bit.
- R3: For a non-exceptional result, the lower EXP_W+FRAC_W bits of `q_o` form the {exponent, fraction} magnitude. Read as an unsigned integer, this magnitude is never greater than that of the exactly truncated quotient and is at most 2 below it.
- R4: `done_o` is high exactly when `ready_i` was high at the rising edge four edges earlier, counting the edge that samples `ready_i`. The block accepts a new operation on every clock, with no gaps needed.
- R5: An operation presented with `exc_i` high completes with `exc_o` high.
- R6: If either operand's exponent field is all zeros or all ones (zero, subnormal, infinity or NaN), the operation completes with `exc_o` high.
- R7: If the result exponent, after the one-step normalisation, is 0 or less, or is 2^EXP_W−1 or more, `exc_o` is high. If it lies strictly between those limits, `exc_o` stays low, provided R5 and R6 do not apply.
- R8: While `rst_ni` is low, `done_o` and `exc_o` are low, whatever the inputs do.
- R9: A divisor with an all-zero fraction field gives an exact result: the quotient fraction equals the dividend fraction, and the exponent equals ea − eb + bias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Operands on opa_i/opb_i are valid this cycle |
| exc_i | input | 1 | Upstream exception flag for this operation |
| opa_i | input | 1+EXP_W+FRAC_W | Dividend as {sign, exponent, fraction} |
| opb_i | input | 1+EXP_W+FRAC_W | Divisor as {sign, exponent, fraction} |
| q_o | output | 1+EXP_W+FRAC_W | Quotient as {sign, exponent, fraction} |
| done_o | output | 1 | q_o and exc_o hold a completed operation |
| exc_o | output | 1 | Exception flag for the completed operation |

## Verification
Several properties are checked on every cycle: the four-clock alignment of `done_o` with `ready_i`, the delivery of the upstream and special-operand exception flags, the sign, the legal range of the exponent field on clean results, the exactness of divisions by a power-of-two mantissa, and quiet outputs during reset. The numerical quality of the quotient cannot be expressed as a cycle property. This covers the bound of two units below the truncated quotient and the decremented exponent when the dividend mantissa is the smaller one. Only the bench can show these, because it compares each result against an exact integer quotient. It does this over random operands, over back-to-back and gapped streams, and at the exponent limits where a result just fits or just overflows.

// File: rtl/fpdiv_pkg.sv
`timescale 1ns/1ps
package fpdiv_pkg;

  localparam int unsigned PIPE_LAT = 4;

  // floor(2^(tf+2*hw) / (2^hw + idx)^2): 1/Yh^2 with tf fraction bits
  function automatic logic [63:0] recip_sq(input int unsigned idx,
                                           input int unsigned hw,
                                           input int unsigned tf);
    logic [63:0] den;
    logic [63:0] num;
    den = (64'd1 << hw) + 64'(idx);
    den = den * den;
    num = 64'd1 << (tf + 2 * hw);
    return num / den;
  endfunction

endpackage

// File: rtl/fpdiv_delay.sv
`timescale 1ns/1ps
module fpdiv_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);

  logic [DEPTH-1:0][WIDTH-1:0] sr;

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr <= '0;
      else         sr[0] <= d_i;
    end
  end else begin : g_many
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr <= '0;
      else         sr <= {sr[DEPTH-2:0], d_i};
    end
  end

  assign d_o = sr[DEPTH-1];

endmodule

// File: rtl/fpdiv_recip_rom.sv
`timescale 1ns/1ps
module fpdiv_recip_rom #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned T_W   = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic [T_W-1:0]   t_o
);

  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned T_FRAC = T_W - 1;

  logic [T_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [63:0] VAL = fpdiv_pkg::recip_sq(i, IDX_W, T_FRAC);
    assign tbl[i] = VAL[T_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t_o <= '0;
    else         t_o <= tbl[idx_i];
  end

endmodule

// File: rtl/fpdiv_front.sv
`timescale 1ns/1ps
module fpdiv_front #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned IDX_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ready_i,
  input  logic                     exc_i,
  input  logic [EXP_W+FRAC_W:0]    opa_i,
  input  logic [EXP_W+FRAC_W:0]    opb_i,
  output logic [IDX_W-1:0]         idx_o,
  output logic [FRAC_W:0]          x_o,
  output logic [FRAC_W:0]          d_o,
  output logic                     vld_o,
  output logic                     sgn_o,
  output logic signed [EXP_W+1:0]  exp_o,
  output logic                     exc_o
);

  localparam int unsigned W    = 1 + EXP_W + FRAC_W;
  localparam int unsigned MW   = FRAC_W + 1;
  localparam int unsigned LO_W = FRAC_W - IDX_W;
  localparam int unsigned ES   = EXP_W + 2;
  localparam logic signed [ES-1:0] BIAS_S = ES'((1 << (EXP_W - 1)) - 1);

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic [MW-1:0]     yh, yl, diff;
  logic signed [ES-1:0] e_raw;
  logic              special;

  assign ea = opa_i[W-2 -: EXP_W];
  assign eb = opb_i[W-2 -: EXP_W];
  assign fa = opa_i[FRAC_W-1:0];
  assign fb = opb_i[FRAC_W-1:0];

  // divisor split: Yh = 1.hi (table index), Yl = low bits
  assign idx_o = fb[FRAC_W-1 -: IDX_W];
  assign yh    = {1'b1, fb[FRAC_W-1 -: IDX_W], {LO_W{1'b0}}};
  assign yl    = {{(IDX_W+1){1'b0}}, fb[LO_W-1:0]};
  assign diff  = yh - yl;

  assign e_raw   = $signed({2'b00, ea}) - $signed({2'b00, eb}) + BIAS_S;
  assign special = (ea == '0) || (ea == '1) || (eb == '0) || (eb == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o   <= '0;
      d_o   <= '0;
      vld_o <= 1'b0;
      sgn_o <= 1'b0;
      exp_o <= '0;
      exc_o <= 1'b0;
    end else begin
      x_o   <= {1'b1, fa};
      d_o   <= diff;
      vld_o <= ready_i;
      sgn_o <= opa_i[W-1] ^ opb_i[W-1];
      exp_o <= e_raw;
      exc_o <= exc_i | special;
    end
  end

endmodule

// File: rtl/fpdiv_mant_mul.sv
`timescale 1ns/1ps
module fpdiv_mant_mul #(
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned T_W    = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W:0]   x_i,
  input  logic [FRAC_W:0]   d_i,
  input  logic [T_W-1:0]    t_i,
  output logic [FRAC_W+1:0] q_o
);

  localparam int unsigned MW     = FRAC_W + 1;
  localparam int unsigned FULL_W = 2 * MW;
  localparam int unsigned P1_W   = FRAC_W + 6;        // 2 integer + FRAC_W+4 fraction
  localparam int unsigned DROP1  = FULL_W - P1_W;
  localparam int unsigned PR_W   = P1_W + T_W;
  localparam int unsigned Q_W    = FRAC_W + 2;        // 1 integer + FRAC_W+1 fraction
  localparam int unsigned DROP2  = (2 * FRAC_W + 9) - (FRAC_W + 1);

  logic [FULL_W-1:0] full;
  logic [P1_W-1:0]   p1_q;
  logic [T_W-1:0]    t_q;
  logic [PR_W-1:0]   prod;

  // X * (Yh - Yl)
  assign full = FULL_W'(x_i) * FULL_W'(d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
      t_q  <= '0;
    end else begin
      p1_q <= P1_W'(full >> DROP1);
      t_q  <= t_i;
    end
  end

  // times 1/Yh^2
  assign prod = PR_W'(p1_q) * PR_W'(t_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= Q_W'(prod >> DROP2);
  end

endmodule

// File: rtl/fpdiv_norm.sv
`timescale 1ns/1ps
module fpdiv_norm #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [FRAC_W+1:0]       q_i,
  input  logic                    vld_i,
  input  logic                    sgn_i,
  input  logic signed [EXP_W+1:0] exp_i,
  input  logic                    exc_i,
  output logic [EXP_W+FRAC_W:0]   q_o,
  output logic                    done_o,
  output logic                    exc_o
);

  localparam int unsigned ES = EXP_W + 2;
  localparam logic signed [ES-1:0] E_TOP = ES'((1 << EXP_W) - 1);
  localparam logic signed [ES-1:0] E_ONE = ES'(1);
  localparam logic signed [ES-1:0] E_NIL = '0;

  logic signed [ES-1:0] e_adj;
  logic [FRAC_W-1:0]    frac;
  logic                 out_rng;

  always_comb begin
    if (q_i[FRAC_W+1]) begin
      e_adj = exp_i;
      frac  = q_i[FRAC_W:1];
    end else begin
      // quotient below 1: one left shift, exponent minus one
      e_adj = exp_i - E_ONE;
      frac  = q_i[FRAC_W-1:0];
    end
    out_rng = (e_adj <= E_NIL) || (e_adj >= E_TOP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o    <= '0;
      done_o <= 1'b0;
      exc_o  <= 1'b0;
    end else begin
      q_o    <= {sgn_i, e_adj[EXP_W-1:0], frac};
      done_o <= vld_i;
      exc_o  <= vld_i & (exc_i | out_rng);
    end
  end

endmodule

// File: rtl/fpdiv_taylor.sv
`timescale 1ns/1ps
module fpdiv_taylor #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned IDX_W  = (FRAC_W + 1) / 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ready_i,
  input  logic                  exc_i,
  input  logic [EXP_W+FRAC_W:0] opa_i,
  input  logic [EXP_W+FRAC_W:0] opb_i,
  output logic [EXP_W+FRAC_W:0] q_o,
  output logic                  done_o,
  output logic                  exc_o
);

  localparam int unsigned MW   = FRAC_W + 1;
  localparam int unsigned ES   = EXP_W + 2;
  localparam int unsigned T_W  = FRAC_W + 6;
  localparam int unsigned SB_W = 3 + ES;
  localparam int unsigned SB_D = fpdiv_pkg::PIPE_LAT - 2;

  logic [IDX_W-1:0]     idx;
  logic [MW-1:0]        x_s1, d_s1;
  logic [T_W-1:0]       t_s1;
  logic                 vld_s1, sgn_s1, exc_s1;
  logic signed [ES-1:0] exp_s1;
  logic [FRAC_W+1:0]    q_s3;
  logic [SB_W-1:0]      side_s1, side_s3;
  logic                 vld_s3, sgn_s3, exc_s3;
  logic signed [ES-1:0] exp_s3;

  fpdiv_front #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready_i),
    .exc_i   (exc_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .idx_o   (idx),
    .x_o     (x_s1),
    .d_o     (d_s1),
    .vld_o   (vld_s1),
    .sgn_o   (sgn_s1),
    .exp_o   (exp_s1),
    .exc_o   (exc_s1)
  );

  fpdiv_recip_rom #(.IDX_W(IDX_W), .T_W(T_W)) u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx),
    .t_o    (t_s1)
  );

  fpdiv_mant_mul #(.FRAC_W(FRAC_W), .T_W(T_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_s1),
    .d_i    (d_s1),
    .t_i    (t_s1),
    .q_o    (q_s3)
  );

  assign side_s1 = {vld_s1, sgn_s1, exc_s1, exp_s1};

  fpdiv_delay #(.WIDTH(SB_W), .DEPTH(SB_D)) u_side (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (side_s1),
    .d_o    (side_s3)
  );

  assign {vld_s3, sgn_s3, exc_s3} = side_s3[SB_W-1 -: 3];
  assign exp_s3 = $signed(side_s3[ES-1:0]);

  fpdiv_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .q_i    (q_s3),
    .vld_i  (vld_s3),
    .sgn_i  (sgn_s3),
    .exp_i  (exp_s3),
    .exc_i  (exc_s3),
    .q_o    (q_o),
    .done_o (done_o),
    .exc_o  (exc_o)
  );

endmodule

// File: rtl/fpdiv_taylor_chk.sv
`timescale 1ns/1ps
module fpdiv_taylor_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ready_i,
  input logic                  exc_i,
  input logic [EXP_W+FRAC_W:0] opa_i,
  input logic [EXP_W+FRAC_W:0] opb_i,
  input logic [EXP_W+FRAC_W:0] q_o,
  input logic                  done_o,
  input logic                  exc_o
);

  localparam int unsigned W = 1 + EXP_W + FRAC_W;

  logic [2:0] warm_cnt;
  logic       warm;
  logic       in_special, in_sgn, b_pow2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                warm_cnt <= '0;
    else if (warm_cnt != 3'd4)  warm_cnt <= warm_cnt + 3'd1;
  end
  assign warm = (warm_cnt == 3'd4);

  assign in_special = (opa_i[W-2 -: EXP_W] == '0) || (opa_i[W-2 -: EXP_W] == '1) ||
                      (opb_i[W-2 -: EXP_W] == '0) || (opb_i[W-2 -: EXP_W] == '1);
  assign in_sgn     = opa_i[W-1] ^ opb_i[W-1];
  assign b_pow2     = (opb_i[FRAC_W-1:0] == '0);

  p_done_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (done_o == $past(ready_i, 4)));

  p_exc_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(ready_i && exc_i, 4)) |-> exc_o);

  p_special_exc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(ready_i && in_special, 4)) |-> exc_o);

  p_sign_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && done_o && !exc_o) |-> (q_o[W-1] == $past(in_sgn, 4)));

  p_exp_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !exc_o) |-> ((q_o[W-2 -: EXP_W] != '0) && (q_o[W-2 -: EXP_W] != '1)));

  p_pow2_exact_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && done_o && !exc_o && $past(b_pow2, 4)) |->
      (q_o[FRAC_W-1:0] == $past(opa_i[FRAC_W-1:0], 4)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r8: assert (!done_o && !exc_o);
    end
  end

endmodule

bind fpdiv_taylor fpdiv_taylor_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (ready_i),
  .exc_i   (exc_i),
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .q_o     (q_o),
  .done_o  (done_o),
  .exc_o   (exc_o)
);

// File: tb/sim_fpdiv_taylor.sv
`timescale 1ns/1ps
module sim_fpdiv_taylor;

  localparam int E    = 8;
  localparam int F    = 23;
  localparam int BIAS = 127;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rdy = 1'b0;
  logic        exci = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [31:0] q;
  logic        done;
  logic        exco;

  always #2.5 clk = ~clk;

  fpdiv_taylor #(.EXP_W(E), .FRAC_W(F)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .ready_i (rdy),
    .exc_i   (exci),
    .opa_i   (a),
    .opb_i   (b),
    .q_o     (q),
    .done_o  (done),
    .exc_o   (exco)
  );

  typedef struct packed {
    logic        vld;
    logic        exc;
    logic        sgn;
    logic        lt;
    logic        pow2;
    logic [7:0]  ex;
    logic [30:0] mag;
  } exp_t;

  exp_t sb [4];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   fin = 1'b0;

  function automatic exp_t model(input logic [31:0] x, input logic [31:0] y,
                                 input logic xi, input logic rv);
    exp_t   r;
    int     ea, eb, e;
    longint ma, mb, m;
    r      = '0;
    r.vld  = rv;
    ea     = int'(x[30:23]);
    eb     = int'(y[30:23]);
    ma     = longint'({1'b1, x[22:0]});
    mb     = longint'({1'b1, y[22:0]});
    r.sgn  = x[31] ^ y[31];
    r.lt   = (ma < mb);
    r.pow2 = (y[22:0] == '0);
    e      = ea - eb + BIAS;
    if (ma >= mb) m = (ma << 23) / mb;
    else begin
      m = (ma << 24) / mb;
      e = e - 1;
    end
    r.ex  = 8'(e);
    r.mag = {8'(e), 23'(m)};
    r.exc = xi || ea == 0 || ea == 255 || eb == 0 || eb == 255 || e <= 0 || e >= 255;
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] got,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, expv);
    end
  endtask

  task automatic cycle(input logic rv, input logic [31:0] x, input logic [31:0] y,
                       input logic xi);
    exp_t   ce;
    longint dif;
    @(negedge clk);
    ce = sb[3];
    chk(done === ce.vld, "R4 done alignment", 64'(done), 64'(ce.vld));
    if (ce.vld) begin
      chk(exco === ce.exc, "R5 R6 R7 exception flag", 64'(exco), 64'(ce.exc));
      if (!ce.exc && !exco) begin
        chk(q[31] === ce.sgn, "R1 sign", 64'(q[31]), 64'(ce.sgn));
        dif = longint'(ce.mag) - longint'(q[30:0]);
        chk(dif >= 0 && dif <= 2, "R3 magnitude bound", 64'(q[30:0]), 64'(ce.mag));
        if (ce.lt)   chk(q[30:23] === ce.ex, "R2 decremented exponent", 64'(q[30:23]), 64'(ce.ex));
        if (ce.pow2) chk(q[30:0] === ce.mag, "R9 exact power-of-two divisor", 64'(q[30:0]), 64'(ce.mag));
      end
    end
    sb[3] = sb[2];
    sb[2] = sb[1];
    sb[1] = sb[0];
    sb[0] = model(x, y, xi, rv);
    rdy   = rv;
    a     = x;
    b     = y;
    exci  = xi;
  endtask

  function automatic logic [31:0] rnd_op(input int emin, input int emax);
    logic [31:0] r;
    r[31]    = 1'($urandom);
    r[30:23] = 8'(emin + int'($urandom % 32'(emax - emin + 1)));
    r[22:0]  = 23'($urandom);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog expired got=0 exp=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, y;
    void'($urandom(32'd20240917));
    for (int i = 0; i < 4; i++) sb[i] = '0;

    // R8: reset keeps outputs quiet even with ready asserted
    rdy = 1'b1; exci = 1'b1; a = 32'h3FC00000; b = 32'h3F800000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(done === 1'b0 && exco === 1'b0, "R8 reset quiet", 64'({done, exco}), 64'd0);
    end
    rdy = 1'b0; exci = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    cycle(1'b1, 32'h3FC00000, 32'h3FC00000, 1'b0);   // 1.5/1.5 near binade edge
    cycle(1'b1, 32'h40490FDB, 32'h40000000, 1'b0);   // pow2 divisor R9
    cycle(1'b1, 32'hBFFFFFFF, 32'h3F800000, 1'b0);   // max mantissa / 1.0, negative
    cycle(1'b1, 32'h3F800000, 32'h3FFFFFFF, 1'b0);   // 1.0 / max mantissa R2
    cycle(1'b1, 32'h3F800000, 32'hBFC00001, 1'b0);
    cycle(1'b1, 32'h3FC00000, 32'h3F800000, 1'b1);   // R5 upstream flag
    cycle(1'b1, 32'h3FC00000, 32'h00000000, 1'b0);   // R6 zero divisor
    cycle(1'b1, 32'h7F800000, 32'h3F800000, 1'b0);   // R6 infinity
    cycle(1'b1, 32'h3F800000, 32'h7FC00000, 1'b0);   // R6 NaN
    cycle(1'b1, 32'h00000000, 32'h3F800000, 1'b0);   // R6 zero dividend
    cycle(1'b1, 32'h7D000000, 32'h02800000, 1'b0);   // R7 overflow
    cycle(1'b1, 32'h02800000, 32'h7D000000, 1'b0);   // R7 underflow
    cycle(1'b1, 32'h7F7FFFFF, 32'h3F800000, 1'b0);   // R7 exponent 254 fits
    cycle(1'b1, 32'h7F7FFFFF, 32'h3F000000, 1'b0);   // R7 exponent 255 -> exception
    cycle(1'b1, 32'h00C00000, 32'h3F800000, 1'b0);   // R7 exponent 1 fits
    cycle(1'b1, 32'h00800000, 32'h3FC00000, 1'b0);   // R7 exponent 0 -> exception
    cycle(1'b0, 32'h3F800000, 32'h3F800000, 1'b1);   // bubble: ignored
    cycle(1'b1, 32'h3F800000, 32'h3F800000, 1'b0);

    // random stream, back-to-back and gapped
    for (int i = 0; i < 2000; i++) begin
      x = rnd_op(70, 184);
      y = rnd_op(70, 184);
      if (($urandom % 20) == 0) y[22:0] = '0;
      if (($urandom % 25) == 0) x[30:23] = ($urandom % 2) ? 8'hFF : 8'h00;
      if (($urandom % 25) == 0) y[30:23] = ($urandom % 2) ? 8'hFF : 8'h00;
      cycle(1'(($urandom % 5) != 0), x, y, 1'(($urandom % 20) == 0));
    end

    for (int i = 0; i < 6; i++) cycle(1'b0, '0, '0, 1'b0);

    fin = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule